// File: doc/BRIEF.md
# Serial Bit-Time Measurement Counter

This block times intervals on a serial receive line with a 9-bit counter. It is used to recover an unknown incoming baud rate and to measure the length of a received break. The receive line is synchronised to the bus clock before any edge is detected. The counter advances once for every two pulses of its selected clock source.

There are two timing modes.

- **Edge mode** (clock-select 0): the counter runs from one falling edge to the next falling edge. It is clocked at half the bus rate.
- **Low-time mode** (clock-select 1): the counter starts as soon as the line is seen low and stops on the next rising edge. It is clocked at half the rate of an external prescaled serial-clock enable.

A two-bit mode-select field enables measurement when it is non-zero. When a measurement completes, the finished flag is raised and the result stays frozen. Software reads the result and then writes the control register, which clears the counter and the overflow flag and arms the next measurement.

Top module: `bit_time_meter`

## Requirements
- R1: After reset the counter is 0 and the running, finished and overflow flags are all 0.
- R2: With clock-select 0, a synchronised falling edge on the receive line starts the counter, and the next falling edge stops it. While it runs, the count rises by one on every second bus clock. Two falling edges G bus clocks apart leave a count of (G-1)/2, rounded down.
- R3: In edge mode, the finished flag is set when the second falling edge stops the counter. Running and finished are never 1 at the same time.
- R4: With clock-select 1, a low level on the synchronised line starts the counter, and the next rising edge stops it and sets finished. The count rises by one on every second pulse of the serial-clock enable. With that enable held at 1, a low time of L bus clocks leaves a count of (L-1)/2, rounded down.
- R5: In low-time mode, if the line is already low when the mode-select field becomes non-zero, counting starts without waiting for an edge. Running is 1 within two clocks.
- R6: The running output is 1 exactly while the counter is between its start and stop conditions.
- R7: When the count passes 511, the counter wraps to 0, the overflow flag is set, and counting continues until the stop condition.
- R8: A pulse on the control-write strobe clears all 9 counter bits and the overflow flag. If the finished flag is set, the pulse also clears it and re-arms the block.
- R9: While mode-select is 00, the counter and all three flags are held at 0 and no measurement starts.
- R10: While finished is 1 and no control write occurs, further line activity changes neither the count nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_en | input | 1 | Prescaled serial-clock enable pulse |
| rxd | input | 1 | Serial receive line, idle high |
| mode_sel | input | 2 | Measurement enable; 00 holds the block idle |
| clk_sel | input | 1 | 0 = edge mode on the bus clock, 1 = low-time mode on the serial-clock enable |
| ctl_wr | input | 1 | Control-register write strobe |
| cnt_lo | output | 8 | Low 8 bits of the counter |
| cnt_msb | output | 1 | Top bit of the counter |
| running | output | 1 | Counter is running |
| finished | output | 1 | Measurement has completed |
| overflow | output | 1 | Counter has wrapped |

## Verification
The bench builds the block with its default 9-bit counter and a two-stage synchroniser. This keeps an overflow within reach: roughly a thousand bus clocks of edge-mode timing wrap the counter, and the wrap is then followed through to the stop. A serial-clock enable that pulses every third cycle exercises the low-time divider at a rate that differs from the bus clock. Holding that enable at 1 makes the closed-form counts of R2 and R4 directly checkable.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_COUNT = 2'd1,
    ST_HELD  = 2'd2
  } btm_state_e;

  // Start condition: a low level in low-time mode, a falling edge in edge mode.
  function automatic logic start_hit(input logic level_mode, input logic rx_lvl,
                                     input logic rx_fall);
    return level_mode ? ~rx_lvl : rx_fall;
  endfunction

  // Stop condition: a rising edge in low-time mode, a falling edge in edge mode.
  function automatic logic stop_hit(input logic level_mode, input logic rx_fall,
                                    input logic rx_rise);
    return level_mode ? rx_rise : rx_fall;
  endfunction

endpackage

// File: rtl/btm_rx_sync.sv
module btm_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_lvl,
  output logic rx_fall,
  output logic rx_rise
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= rx_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_lvl <= 1'b1;
    else        last_lvl <= chain[STAGES-1];

  assign rx_lvl  = chain[STAGES-1];
  assign rx_fall = last_lvl & ~rx_lvl;
  assign rx_rise = ~last_lvl & rx_lvl;

  // R2
  fall_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fall |=> !rx_fall);
endmodule

// File: rtl/btm_half_tick.sv
module btm_half_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic src_en,
  output logic tick
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      phase <= 1'b0;
    else if (!run)   phase <= 1'b0;
    else if (src_en) phase <= ~phase;

  assign tick = run & src_en & phase;

  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/btm_core.sv
module btm_core
  import btm_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             level_mode,
  input  logic             ctl_wr,
  input  logic             rx_lvl,
  input  logic             rx_fall,
  input  logic             rx_rise,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             finished,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] v);
    return {(v == CNT_TOP), v + 1'b1};
  endfunction

  btm_state_e       state;
  logic             start_ev, stop_ev;
  logic [CNT_W:0]   bumped;

  assign start_ev = start_hit(level_mode, rx_lvl, rx_fall);
  assign stop_ev  = stop_hit(level_mode, rx_fall, rx_rise);
  assign bumped   = bump(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ARMED;
      count    <= '0;
      finished <= 1'b0;
      overflow <= 1'b0;
    end else if (!enable) begin
      state    <= ST_ARMED;
      count    <= '0;
      finished <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (ctl_wr) begin
        count    <= '0;
        overflow <= 1'b0;
      end
      case (state)
        ST_ARMED: if (start_ev) state <= ST_COUNT;
        ST_COUNT: begin
          if (stop_ev) begin
            state    <= ST_HELD;
            finished <= 1'b1;
          end else if (tick && !ctl_wr) begin
            count <= bumped[CNT_W-1:0];
            if (bumped[CNT_W]) overflow <= 1'b1;
          end
        end
        ST_HELD: if (ctl_wr) begin
          state    <= ST_ARMED;
          finished <= 1'b0;
        end
        default: state <= ST_ARMED;
      endcase
    end
  end

  assign running = (state == ST_COUNT);

  // R3
  run_fin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && finished));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0) && !running && !finished && !overflow);
  // R8
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (count == '0) && !overflow);
  // R7
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (count == '0) && running);
  // R10
  frozen_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && enable && !ctl_wr) |=> finished && $stable(count) && $stable(overflow));
endmodule

// File: rtl/bit_time_meter.sv
module bit_time_meter #(
  parameter int CNT_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_en,
  input  logic             rxd,
  input  logic [1:0]       mode_sel,
  input  logic             clk_sel,
  input  logic             ctl_wr,
  output logic [CNT_W-2:0] cnt_lo,
  output logic             cnt_msb,
  output logic             running,
  output logic             finished,
  output logic             overflow
);
  logic             rx_lvl, rx_fall, rx_rise;
  logic             src_en, tick, enable;
  logic [CNT_W-1:0] count;

  assign enable = |mode_sel;
  assign src_en = clk_sel ? sclk_en : 1'b1;

  btm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_in(rxd),
    .rx_lvl(rx_lvl), .rx_fall(rx_fall), .rx_rise(rx_rise)
  );

  btm_half_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(running), .src_en(src_en), .tick(tick)
  );

  btm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .level_mode(clk_sel),
    .ctl_wr(ctl_wr), .rx_lvl(rx_lvl), .rx_fall(rx_fall), .rx_rise(rx_rise),
    .tick(tick), .count(count), .running(running), .finished(finished),
    .overflow(overflow)
  );

  assign cnt_lo  = count[CNT_W-2:0];
  assign cnt_msb = count[CNT_W-1];

  // R6
  count_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && enable && !ctl_wr) |=> $stable(count));
endmodule

// File: tb/test_bit_time_meter.sv
module test_bit_time_meter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_en = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       clk_sel = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] cnt_lo;
  logic       cnt_msb, running, finished, overflow;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int sclk_div = 0;   // 0: enable held high, else pulse period
  bit done = 0;

  always #2 clk = ~clk;

  bit_time_meter i_bit_time_meter (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .rxd(rxd),
    .mode_sel(mode_sel), .clk_sel(clk_sel), .ctl_wr(ctl_wr),
    .cnt_lo(cnt_lo), .cnt_msb(cnt_msb), .running(running),
    .finished(finished), .overflow(overflow)
  );

  // Behavioural reference: line history, phase and integer count.
  bit rxq[$] = '{1, 1, 1};
  int m_cnt = 0, m_mode = 0;   // mode 0 armed, 1 counting, 2 held
  bit m_fin = 0, m_ovf = 0, m_half = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      rxq = '{1, 1, 1}; m_cnt = 0; m_mode = 0; m_fin = 0; m_ovf = 0; m_half = 0;
    end else begin
      bit lvl, fal, ris, pulse, stp, stt, adv;
      lvl = rxq[1]; fal = rxq[2] && !rxq[1]; ris = !rxq[2] && rxq[1];
      pulse = clk_sel ? sclk_en : 1'b1;
      adv = (m_mode == 1) && pulse && m_half;
      stt = clk_sel ? !lvl : fal;
      stp = clk_sel ? ris : fal;
      m_half = (m_mode == 1) ? (m_half ^ pulse) : 1'b0;
      if (mode_sel == 2'b00) begin
        m_mode = 0; m_cnt = 0; m_fin = 0; m_ovf = 0;
      end else begin
        int prev_mode;
        prev_mode = m_mode;
        if (ctl_wr) begin m_cnt = 0; m_ovf = 0; end
        if (prev_mode == 0 && stt) m_mode = 1;
        else if (prev_mode == 1) begin
          if (stp) begin m_mode = 2; m_fin = 1; end
          else if (adv && !ctl_wr) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == 512) begin m_cnt = 0; m_ovf = 1; end
          end
        end else if (prev_mode == 2 && ctl_wr) begin m_mode = 0; m_fin = 0; end
      end
      rxq.push_front(rxd);
      void'(rxq.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int dut_cnt();
    return {cnt_msb, cnt_lo};
  endfunction

  // Per-clock comparison against the reference, away from the rising edge.
  always @(negedge clk) if (rst_n && !done) begin
    check(dut_cnt() == m_cnt, "R2 count", dut_cnt(), m_cnt);
    check(running == (m_mode == 1), "R6 running", running, m_mode == 1);
    check(finished == m_fin, "R3 finished", finished, m_fin);
    check(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
  end

  always @(posedge clk) begin
    #1;
    if (sclk_div == 0) sclk_en <= 1'b1;
    else sclk_en <= (cyc % sclk_div == 0);
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_wr();
    ctl_wr = 1'b1; cycles(1); ctl_wr = 1'b0;
  endtask

  task automatic probe();
    @(negedge clk); #0.5;
  endtask

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cycles(3);
    probe();
    // R1: reset values
    check(dut_cnt() == 0 && !running && !finished && !overflow, "R1", dut_cnt(), 0);
    rst_n = 1'b1;
    cycles(4);

    // R2/R3: edge mode, falls 40 clocks apart
    mode_sel = 2'b01; clk_sel = 1'b0;
    cycles(3);
    rxd = 0; cycles(10); rxd = 1; cycles(15);
    probe(); check(running == 1, "R6 mid-run", running, 1);
    cycles(15); rxd = 0; cycles(6);
    probe();
    check(dut_cnt() == 19, "R2 edge count", dut_cnt(), 19);
    check(finished == 1 && running == 0, "R3 finished", finished, 1);
    // R10: activity after completion is ignored
    rxd = 1; cycles(7); rxd = 0; cycles(9); rxd = 1; cycles(6);
    probe(); check(dut_cnt() == 19 && finished, "R10 frozen", dut_cnt(), 19);
    pulse_wr(); probe();
    check(dut_cnt() == 0 && !finished, "R8 clear", dut_cnt(), 0);

    // R4: low-time mode, enable held high, low for 30 clocks
    clk_sel = 1'b1; cycles(4);
    rxd = 0; cycles(30); rxd = 1; cycles(6);
    probe();
    check(dut_cnt() == 14, "R4 low count", dut_cnt(), 14);
    check(finished == 1, "R4 finished", finished, 1);
    pulse_wr();

    // R4: divided serial-clock enable
    sclk_div = 3; cycles(4);
    rxd = 0; cycles(60); rxd = 1; cycles(6);
    probe(); check(finished == 1, "R4 divided finish", finished, 1);
    pulse_wr(); sclk_div = 0;

    // R9 then R5: line low while disabled, then enable
    mode_sel = 2'b00; rxd = 0; cycles(10);
    probe();
    check(dut_cnt() == 0 && !running && !finished, "R9 idle", running, 0);
    mode_sel = 2'b10; cycles(2);
    probe(); check(running == 1, "R5 immediate start", running, 1);
    cycles(20); rxd = 1; cycles(6);
    pulse_wr();

    // R7: overflow in edge mode
    clk_sel = 1'b0; cycles(4);
    rxd = 0; cycles(5); rxd = 1; cycles(1100);
    probe();
    check(overflow == 1 && running == 1, "R7 wrap keeps running", overflow, 1);
    rxd = 0; cycles(6);
    probe(); check(finished == 1 && overflow == 1, "R7 stop after wrap", finished, 1);
    pulse_wr(); probe();
    check(overflow == 0 && dut_cnt() == 0, "R8 overflow clear", overflow, 0);
    rxd = 1; cycles(4);

    // R9: disabling mid-run clears everything
    rxd = 0; cycles(5); rxd = 1; cycles(20);
    mode_sel = 2'b00; cycles(2);
    probe(); check(dut_cnt() == 0 && !running, "R9 abort", dut_cnt(), 0);
    // R8: control write during a run restarts the count
    mode_sel = 2'b01; cycles(3);
    rxd = 0; cycles(5); rxd = 1; cycles(30);
    pulse_wr(); probe();
    check(dut_cnt() == 0 && running, "R8 clear while running", dut_cnt(), 0);
    cycles(10);
    summary();
  end

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end
endmodule